// File: doc/BRIEF.md
# Interleaved Cache Block Fill Controller

This block serves a cache miss by fetching one four-word block from a main memory that is split into four banks, with consecutive words placed in consecutive banks. A fill request carries a word address. The controller drops the two low address bits and uses the remaining bits as the row that each bank reads. It spends one cycle sending that row to the banks and waits the bank access time. It then hands the four words to the cache over a one-word bus, one word per cycle, each tagged with its index and a valid strobe. The last word also raises a done strobe.

A mode input, sampled when the request is accepted, selects between two behaviours. In overlapped mode all four banks read together and only the word transfers are serialised, so a fill takes 1 + 6 + 4 = 11 cycles. In single-bank mode each word pays the whole address, access and transfer sequence on its own, so a fill takes 4 × 8 = 32 cycles. After each fill a latency register holds the measured number of cycles. A separate write port, used only to preload test data, writes a word into any row of any bank.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: After reset, fill_ready is 1, word_valid is 0, fill_done is 0 and fill_cycles is 0.
- R2: A request is taken only on a rising edge where fill_ready and req_valid are both 1. From the next cycle, fill_ready stays 0 until the fill ends. A req_valid raised while fill_ready is 0 is ignored: the running fill keeps its data and timing, and no second fill follows it.
- R3: In overlapped mode (req_single = 0), counting the cycle after the accepting edge as cycle 1, word k (k = 0..3) is presented in cycle 8 + k with word_valid = 1 and word_idx = k. word_valid is 0 in every other cycle of the fill.
- R4: In single-bank mode (req_single = 1), word k is presented in cycle 8·(k+1) with word_idx = k. word_valid is 0 in all other cycles, and at most one bank reads in any cycle.
- R5: Word k of a fill is the content of bank k at row req_addr[5:2]. The two low address bits req_addr[1:0] have no effect on the data or the order of the words.
- R6: fill_done is 1 only together with word 3. From the cycle after fill_done, fill_cycles equals the fill length (11 in overlapped mode, 32 in single-bank mode) and keeps that value until the next fill ends.
- R7: The mode is taken from req_single at acceptance. A change of req_single during a fill has no effect on that fill.
- R8: A preload write (pl_we = 1) stores pl_data into bank pl_bank at row pl_row on the rising edge. Fills started after the write return the new value.
- R9: fill_ready is 1 again in the cycle after fill_done, so a request held there is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Block fill request strobe |
| req_addr | input | 6 | Word address; [5:2] row, [1:0] ignored |
| req_single | input | 1 | 1 = single-bank timing, 0 = overlapped banks |
| fill_ready | output | 1 | Controller idle and able to accept a request |
| word_valid | output | 1 | A block word is on word_data |
| word_idx | output | 2 | Index of the word within the block |
| word_data | output | 32 | Returned word |
| fill_done | output | 1 | Strobe with the last word of the block |
| fill_cycles | output | 8 | Measured length in cycles of the last completed fill |
| pl_we | input | 1 | Preload write enable |
| pl_bank | input | 2 | Preload bank select |
| pl_row | input | 4 | Preload row |
| pl_data | input | 32 | Preload data |

## Verification
The embedded properties check on every cycle that acceptance drops fill_ready and that fill_ready comes back right after fill_done. They also check that overlapped-mode words follow each other without gaps in ascending index order, and that single-bank mode leaves an idle bus cycle after each word and never reads more than one bank at a time. On every fill they check that the latency register ends at 11 or 32 for the sampled mode. Only the bench scenarios can show the exact cycle at which each word appears after acceptance, which bank and row supplies each word, and that the low address bits have no effect. The same applies to preload writes, to mode changes and requests raised during a fill, and to back-to-back fills.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_XFER = 2'd3
  } ilv_state_e;

  // Total fill length in cycles for one timing mode.
  function automatic int unsigned fill_latency(input bit single,
                                               input int unsigned words,
                                               input int unsigned addr_cyc,
                                               input int unsigned acc_cyc);
    if (single) return words * (addr_cyc + acc_cyc + 1);
    return addr_cyc + acc_cyc + words;
  endfunction

  // Cycle (1 = first cycle after acceptance) in which word k is returned.
  function automatic int unsigned word_cycle(input bit single,
                                             input int unsigned k,
                                             input int unsigned addr_cyc,
                                             input int unsigned acc_cyc);
    if (single) return (k + 1) * (addr_cyc + acc_cyc + 1);
    return addr_cyc + acc_cyc + 1 + k;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  // Read data is captured when the access time ends and held for transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_row];
  end

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int WORDS    = 4,
  parameter int ROW_W    = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 6,
  localparam int IDX_W   = $clog2(WORDS),
  localparam int PH_MAX  = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC,
  localparam int PH_W    = $clog2(PH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_single,
  output logic             ready,
  output logic             accept,
  output logic             busy,
  output logic             mode_q,
  output logic [WORDS-1:0] bank_rd_en,
  output logic [ROW_W-1:0] row_q,
  output logic             xfer_valid,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             last_word
);

  ilv_state_e       state;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] widx;
  logic             addr_last;
  logic             acc_last;

  assign ready      = (state == ST_IDLE);
  assign accept     = ready && req_valid;
  assign busy       = !ready;
  assign addr_last  = (state == ST_ADDR) && (ph == PH_W'(ADDR_CYC - 1));
  assign acc_last   = (state == ST_ACC)  && (ph == PH_W'(ACC_CYC - 1));
  assign xfer_valid = (state == ST_XFER);
  assign xfer_idx   = widx;
  assign last_word  = xfer_valid && (widx == IDX_W'(WORDS - 1));

  // Overlapped mode opens every bank at once; single-bank mode only the current one.
  for (genvar b = 0; b < WORDS; b++) begin : g_rd_en
    assign bank_rd_en[b] = acc_last && (!mode_q || (widx == IDX_W'(b)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ph     <= '0;
      widx   <= '0;
      row_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state  <= ST_ADDR;
            ph     <= '0;
            widx   <= '0;
            row_q  <= req_row;
            mode_q <= req_single;
          end
        end
        ST_ADDR: begin
          if (addr_last) begin
            state <= ST_ACC;
            ph    <= '0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_ACC: begin
          if (acc_last) begin
            state <= ST_XFER;
            ph    <= '0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_XFER: begin
          if (last_word) begin
            state <= ST_IDLE;
          end else begin
            widx <= widx + IDX_W'(1);
            if (mode_q) state <= ST_ADDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);

  assert_ovl_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !last_word && !mode_q) |=> (xfer_valid && xfer_idx == $past(xfer_idx) + IDX_W'(1)));

  assert_single_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !last_word && mode_q) |=> !xfer_valid);

  assert_single_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> $onehot0(bank_rd_en));

endmodule

// File: rtl/ilv_lat_ctr.sv
module ilv_lat_ctr #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             stop,
  output logic [LAT_W-1:0] fill_cycles
);

  logic [LAT_W-1:0] run_cnt;

  // run_cnt equals the index of the current fill cycle, starting at 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt     <= '0;
      fill_cycles <= '0;
    end else begin
      if (start)     run_cnt <= LAT_W'(1);
      else if (busy) run_cnt <= run_cnt + LAT_W'(1);
      if (stop)      fill_cycles <= run_cnt;
    end
  end

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(fill_cycles));

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl
  import ilv_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ROWS     = 16,
  parameter int WORDS    = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 6,
  parameter int LAT_W    = 8,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int IDX_W   = $clog2(WORDS),
  localparam int ADDR_W  = ROW_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_single,
  output logic              fill_ready,
  output logic              word_valid,
  output logic [IDX_W-1:0]  word_idx,
  output logic [DATA_W-1:0] word_data,
  output logic              fill_done,
  output logic [LAT_W-1:0]  fill_cycles,
  input  logic              pl_we,
  input  logic [IDX_W-1:0]  pl_bank,
  input  logic [ROW_W-1:0]  pl_row,
  input  logic [DATA_W-1:0] pl_data
);

  localparam logic [LAT_W-1:0] LAT_OVL = LAT_W'(fill_latency(1'b0, WORDS, ADDR_CYC, ACC_CYC));
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(fill_latency(1'b1, WORDS, ADDR_CYC, ACC_CYC));

  logic             accept;
  logic             busy;
  logic             mode_q;
  logic [WORDS-1:0] bank_rd_en;
  logic [ROW_W-1:0] row_q;
  logic [DATA_W-1:0] bank_q [WORDS];

  ilv_seq #(
    .WORDS(WORDS), .ROW_W(ROW_W), .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_row    (req_addr[ADDR_W-1 -: ROW_W]),
    .req_single (req_single),
    .ready      (fill_ready),
    .accept     (accept),
    .busy       (busy),
    .mode_q     (mode_q),
    .bank_rd_en (bank_rd_en),
    .row_q      (row_q),
    .xfer_valid (word_valid),
    .xfer_idx   (word_idx),
    .last_word  (fill_done)
  );

  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    ilv_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pl_we && (pl_bank == IDX_W'(b))),
      .wr_row  (pl_row),
      .wr_data (pl_data),
      .rd_en   (bank_rd_en[b]),
      .rd_row  (row_q),
      .rd_q    (bank_q[b])
    );
  end

  assign word_data = word_valid ? bank_q[word_idx] : '0;

  ilv_lat_ctr #(.LAT_W(LAT_W)) lat_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .busy        (busy),
    .stop        (fill_done),
    .fill_cycles (fill_cycles)
  );

  assert_ready_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> fill_ready);

  assert_latency_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (fill_cycles == ($past(mode_q) ? LAT_ONE : LAT_OVL)));

endmodule

// File: tb/ilv_fill_ctrl_tb.sv
module ilv_fill_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_addr = '0;
  logic        req_single = 1'b0;
  logic        fill_ready;
  logic        word_valid;
  logic [1:0]  word_idx;
  logic [31:0] word_data;
  logic        fill_done;
  logic [7:0]  fill_cycles;
  logic        pl_we = 1'b0;
  logic [1:0]  pl_bank = '0;
  logic [3:0]  pl_row = '0;
  logic [31:0] pl_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] model [4][16];

  always #4 clk = ~clk;

  ilv_fill_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_single(req_single), .fill_ready(fill_ready), .word_valid(word_valid),
    .word_idx(word_idx), .word_data(word_data), .fill_done(fill_done),
    .fill_cycles(fill_cycles), .pl_we(pl_we), .pl_bank(pl_bank),
    .pl_row(pl_row), .pl_data(pl_data)
  );

  function automatic int exp_len(input bit single);
    return single ? 4 * 8 : 1 + 6 + 4;
  endfunction

  function automatic int exp_at(input bit single, input int k);
    return single ? 8 * (k + 1) : 8 + k;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input int b, input int r, input logic [31:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_bank = 2'(b); pl_row = 4'(r); pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    model[b][r] = d;
  endtask

  // Entered at a negedge with fill_ready = 1; returns at the negedge of cycle L+1.
  task automatic do_fill(input logic [5:0] addr, input bit single,
                         input bit flip_mode, input bit poke_req);
    int L;
    int k;
    int bad_t;
    int row;
    bit ev;
    string rq;
    L = exp_len(single);
    row = int'(addr[5:2]);
    k = 0;
    bad_t = 0;
    rq = single ? "R4" : "R3";
    req_addr = addr; req_single = single; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int n = 1; n <= L; n++) begin
      @(negedge clk);
      if (flip_mode && n == 3) req_single = !single;
      if (poke_req && n == 5) begin req_valid = 1'b1; req_addr = addr ^ 6'h3C; end
      if (poke_req && n == 6) req_valid = 1'b0;
      ev = (k < 4) && (n == exp_at(single, k));
      if (fill_ready !== 1'b0) bad_t++;
      if (word_valid !== ev) bad_t = bad_t + 1;
      if (ev) begin
        chk(word_idx == 2'(k), rq, "word index", word_idx, k);
        chk(word_data == model[k][row], "R5", "word data", word_data, model[k][row]);
        chk(fill_done == (k == 3), "R6", "done with last word only", fill_done, k == 3);
        k++;
      end else if (fill_done !== 1'b0) begin
        bad_t++;
      end
    end
    chk(bad_t == 0 && k == 4, rq, "word timing mismatches", bad_t, 0);
    if (flip_mode) chk(bad_t == 0, "R7", "mode change mid-fill", bad_t, 0);
    if (poke_req)  chk(bad_t == 0, "R2", "request while busy", bad_t, 0);
    req_single = single;
    @(negedge clk);
    chk(fill_ready == 1'b1, "R9", "ready after done", fill_ready, 1);
    chk(fill_cycles == 8'(L), "R6", "latency register", fill_cycles, L);
    chk(word_valid == 1'b0, rq, "bus idle after fill", word_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(fill_ready == 1'b1 && word_valid == 1'b0 && fill_done == 1'b0 && fill_cycles == 8'd0,
        "R1", "reset state", {fill_ready, word_valid, fill_done, fill_cycles}, 11'h400);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fill_ready == 1'b1, "R1", "idle after reset", fill_ready, 1);

    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 16; r++)
        preload(b, r, $urandom);

    // Directed corner cases
    do_fill(6'h00, 1'b0, 1'b0, 1'b0);
    do_fill(6'h3F, 1'b1, 1'b0, 1'b0);
    do_fill(6'h17, 1'b0, 1'b1, 1'b0);
    do_fill(6'h22, 1'b1, 1'b1, 1'b0);
    do_fill(6'h09, 1'b0, 1'b0, 1'b1);
    do_fill(6'h31, 1'b1, 1'b0, 1'b1);
    // latency register holds while idle
    repeat (5) @(negedge clk);
    chk(fill_cycles == 8'd32 && fill_ready == 1'b1, "R6", "latency held while idle", fill_cycles, 32);
    chk(fill_ready == 1'b1 && word_valid == 1'b0, "R2", "no fill from ignored request",
        word_valid, 0);

    // Preload overwrite visible to later fill
    preload(2, 5, 32'hDEAD_BEEF);
    do_fill(6'h14, 1'b0, 1'b0, 1'b0);
    chk(model[2][5] == 32'hDEAD_BEEF, "R8", "preload model", model[2][5], 32'hDEAD_BEEF);
    preload(0, 5, 32'h0BAD_F00D);
    do_fill(6'h16, 1'b1, 1'b0, 1'b0);

    // Random fills, back to back
    for (int i = 0; i < 24; i++) begin
      logic [5:0] a;
      a = 6'($urandom);
      do_fill(a, 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule